// File: doc/BRIEF.md
# Selectable Half-Band Interpolator Cascade

This block raises the sample rate of a complex I/Q stream by a factor of 1, 2, 4 or 8. Up to three x2 half-band stages sit in a chain. A single 3-bit rate field decides how many of them, counted from the front of the chain, take part. Each active stage puts a zero between consecutive samples and low-pass filters the result with the fixed kernel [-1, 0, 9, 16, 9, 0, -1]/16. The zero taps split each stage into two output phases. One phase needs a short four-term sum. The other phase is a delayed copy of an earlier input.

Everything runs on one processing clock. The source presents a sample with `inValid` no more often than once per IP clocks, where IP is the selected factor. The block then emits exactly IP output samples per input sample, one per `outValid` pulse. Each stage clips its filtered phase to the 20-bit output range. When a stage clips, it raises its own sticky status bit, which stays set until a one is written to the matching bit of `clearSat`.

Top module: `hbc_interp`

## Requirements
- R1: `rateSel` encoding: 0 selects x1, 1 selects x2, 2 selects x4, and any value from 3 to 7 selects x8. Every accepted input sample yields exactly IP output samples, each marked by one `outValid` pulse.
- R2: In x1 mode no stage is used. The output is the input sign-extended and multiplied by 4 (two extra low bits), one clock after `inValid`.
- R3: For stage input samples x[k], with g = 2 for the first stage and g = 0 for the later stages, a stage emits two results in this order. The first is floor((-x[k] + 9x[k-1] + 9x[k-2] - x[k-3]) * 2^g / 16). The second is x[k-1] * 2^g. The stage history starts at zero after reset.
- R4: In x2 mode the output is the first stage's result stream.
- R5: In x4 mode the first stage feeds the second stage, and the second stage's stream is the output.
- R6: In x8 mode (`rateSel` 3 to 7) all three stages are chained, and the third stage's stream is the output.
- R7: A first-phase result outside the signed 20-bit range is clipped to 524287 or to -524288.
- R8: `satFlags` bit s (stage 1 is bit 0) becomes set when stage s+1 clips in either lane, and it stays set.
- R9: A one in `clearSat` bit s clears `satFlags` bit s on the next edge and leaves the other bits untouched. A clip in the same cycle wins over the clear.
- R10: A stage that the rate field leaves out never sets its flag. In x1 mode, even full-scale input leaves `satFlags` at zero.
- R11: While `rst` is high, `outValid`, `outI`, `outQ` and `satFlags` are driven to zero, and the filter histories are emptied.
- R12: Values on `inI`/`inQ` while `inValid` is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| rateSel | input | 3 | Interpolation rate field |
| inValid | input | 1 | Input sample strobe |
| inI | input | 18 | In-phase input, two's complement |
| inQ | input | 18 | Quadrature input, two's complement |
| clearSat | input | 3 | Write-one-to-clear strobes for the status bits |
| outValid | output | 1 | Output sample strobe |
| outI | output | 20 | In-phase output |
| outQ | output | 20 | Quadrature output |
| satFlags | output | 3 | Sticky per-stage clip status |

## Verification
The assertions assume two things about the inputs. First, `rateSel` is held steady outside reset. Second, `inValid` pulses are at least IP clocks apart. Under those conditions the outstanding-output backlog never goes negative and never exceeds twice the factor. The stimulus changes the rate only while reset is asserted. It spaces input strobes by IP plus a small random slack, and it drives random values on the data buses between strobes.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  localparam int NUM_STAGES = 3;
  localparam int SEL_W = $clog2(NUM_STAGES + 1);

  // Strobes handed from the scheduler to the datapath.
  typedef struct packed {
    logic [NUM_STAGES-1:0] stageEn;    // stage takes part at this rate
    logic [NUM_STAGES-1:0] phaseB;     // emit the copy phase this cycle
    logic [SEL_W-1:0]      lastStage;  // number of active stages
  } hbc_strobes_t;
endpackage

// File: rtl/hbc_stage.sv
// One lane of one x2 half-band stage, kernel [-1 0 9 16 9 0 -1]/16.
module hbc_stage #(
  parameter int IW = 18,
  parameter int OW = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic                 emitB,
  input  logic signed [IW-1:0] inData,
  output logic                 outValid,
  output logic signed [OW-1:0] outData,
  output logic                 satHit
);
  localparam int GROW = OW - IW;
  localparam int SHR  = 4 - GROW;
  localparam int AW   = IW + 6;
  localparam logic signed [AW-1:0] HI_LIM = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW-1:0] LO_LIM = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [IW-1:0] h0, h1, h2;
  logic signed [AW-1:0] xE, e0, e1, e2, acc, scaled;
  logic signed [OW-1:0] phaseA, phaseCopy;
  logic                 over;

  always_comb begin
    xE = AW'(inData);
    e0 = AW'(h0);
    e1 = AW'(h1);
    e2 = AW'(h2);
    // Even phase: the zero-stuffed taps leave four terms.
    acc = (e0 <<< 3) + e0 + (e1 <<< 3) + e1 - xE - e2;
    scaled = acc >>> SHR;
    over = 1'b0;
    phaseA = scaled[OW-1:0];
    if (scaled > HI_LIM) begin
      phaseA = HI_LIM[OW-1:0];
      over = 1'b1;
    end else if (scaled < LO_LIM) begin
      phaseA = LO_LIM[OW-1:0];
      over = 1'b1;
    end
    // Odd phase: only the centre tap survives.
    phaseCopy = OW'(h1) <<< GROW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h0 <= '0;
      h1 <= '0;
      h2 <= '0;
      outData <= '0;
      outValid <= 1'b0;
      satHit <= 1'b0;
    end else begin
      outValid <= 1'b0;
      satHit <= 1'b0;
      if (inValid) begin
        h0 <= inData;
        h1 <= h0;
        h2 <= h1;
        outData <= phaseA;
        outValid <= 1'b1;
        satHit <= over;
      end else if (emitB) begin
        outData <= phaseCopy;
        outValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hbc_ctrl.sv
// Rate decode and per-stage scheduling of the second output phase.
module hbc_ctrl
  import hbc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            rateSel,
  input  logic [NUM_STAGES-1:0] stageInValid,
  output hbc_strobes_t          strobes
);
  localparam int CNT_W = NUM_STAGES;

  logic [SEL_W-1:0]      activeCount;
  logic [NUM_STAGES-1:0] enVec, pbVec;

  always_comb begin
    if (rateSel >= 3'(NUM_STAGES)) activeCount = SEL_W'(NUM_STAGES);
    else activeCount = rateSel[SEL_W-1:0];
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : gSched
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] gap;
    // Half the spacing of this stage's input samples.
    assign gap = CNT_W'((32'd1 << activeCount) >> (s + 1));
    assign enVec[s] = activeCount > SEL_W'(s);
    assign pbVec[s] = (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else if (stageInValid[s]) cnt <= gap;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign strobes = '{stageEn: enVec, phaseB: pbVec, lastStage: activeCount};
endmodule

// File: rtl/hbc_datapath.sv
module hbc_datapath
  import hbc_pkg::*;
#(
  parameter int IN_W  = 18,
  parameter int OUT_W = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [IN_W-1:0]   inI,
  input  logic signed [IN_W-1:0]   inQ,
  input  logic [NUM_STAGES-1:0]    clearSat,
  input  hbc_strobes_t             strobes,
  output logic [NUM_STAGES-1:0]    stageInValid,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outI,
  output logic signed [OUT_W-1:0]  outQ,
  output logic [NUM_STAGES-1:0]    satFlags
);
  logic signed [OUT_W-1:0] candI [NUM_STAGES+1];
  logic signed [OUT_W-1:0] candQ [NUM_STAGES+1];
  logic [NUM_STAGES:0]     candValid;
  logic [NUM_STAGES-1:0]   satNow;

  assign candI[0] = OUT_W'(inI) <<< (OUT_W - IN_W);
  assign candQ[0] = OUT_W'(inQ) <<< (OUT_W - IN_W);
  assign candValid[0] = inValid;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : gStage
    localparam int SIW = (s == 0) ? IN_W : OUT_W;
    logic signed [SIW-1:0] srcI, srcQ;
    logic srcValid, vI, vQ, sI, sQ;

    if (s == 0) begin : gFirst
      assign srcI = inI;
      assign srcQ = inQ;
      assign srcValid = inValid;
    end else begin : gNext
      assign srcI = candI[s];
      assign srcQ = candQ[s];
      assign srcValid = candValid[s];
    end

    assign stageInValid[s] = srcValid & strobes.stageEn[s];

    hbc_stage #(.IW(SIW), .OW(OUT_W)) uLaneI (
      .clk(clk), .rst(rst), .inValid(stageInValid[s]), .emitB(strobes.phaseB[s]),
      .inData(srcI), .outValid(vI), .outData(candI[s+1]), .satHit(sI)
    );
    hbc_stage #(.IW(SIW), .OW(OUT_W)) uLaneQ (
      .clk(clk), .rst(rst), .inValid(stageInValid[s]), .emitB(strobes.phaseB[s]),
      .inData(srcQ), .outValid(vQ), .outData(candQ[s+1]), .satHit(sQ)
    );

    assign candValid[s+1] = vI & vQ;
    assign satNow[s] = sI | sQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outI <= '0;
      outQ <= '0;
      satFlags <= '0;
    end else begin
      outValid <= candValid[strobes.lastStage];
      outI <= candI[strobes.lastStage];
      outQ <= candQ[strobes.lastStage];
      satFlags <= (satFlags & ~clearSat) | satNow;
    end
  end
endmodule

// File: rtl/hbc_interp.sv
module hbc_interp
  import hbc_pkg::*;
#(
  parameter int IN_W  = 18,
  parameter int OUT_W = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2:0]              rateSel,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inI,
  input  logic signed [IN_W-1:0]  inQ,
  input  logic [2:0]              clearSat,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outI,
  output logic signed [OUT_W-1:0] outQ,
  output logic [2:0]              satFlags
);
  hbc_strobes_t          strobes;
  logic [NUM_STAGES-1:0] stageInValid;

  hbc_ctrl uCtrl (
    .clk(clk), .rst(rst), .rateSel(rateSel),
    .stageInValid(stageInValid), .strobes(strobes)
  );

  hbc_datapath #(.IN_W(IN_W), .OUT_W(OUT_W)) uData (
    .clk(clk), .rst(rst), .inValid(inValid), .inI(inI), .inQ(inQ),
    .clearSat(clearSat), .strobes(strobes), .stageInValid(stageInValid),
    .outValid(outValid), .outI(outI), .outQ(outQ), .satFlags(satFlags)
  );
endmodule

// File: rtl/hbc_interp_chk.sv
module hbc_interp_chk #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 20
) (
  input logic                    clk,
  input logic                    rst,
  input logic [2:0]              rateSel,
  input logic                    inValid,
  input logic signed [IN_W-1:0]  inI,
  input logic signed [IN_W-1:0]  inQ,
  input logic [2:0]              clearSat,
  input logic                    outValid,
  input logic signed [OUT_W-1:0] outI,
  input logic signed [OUT_W-1:0] outQ,
  input logic [2:0]              satFlags
);
  logic [7:0] pend;
  logic [3:0] factor;

  assign factor = (rateSel >= 3'd3) ? 4'd8 : (4'd1 << rateSel[1:0]);

  // Outputs still owed for the samples taken so far.
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else pend <= pend + (inValid ? {4'd0, factor} : 8'd0) - {7'd0, outValid};
  end

  a_r1_no_excess_output: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (pend != 8'd0));

  a_r1_bounded_backlog: assert property (@(posedge clk) disable iff (rst)
    pend <= {3'd0, factor, 1'b0});

  a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
    (rateSel == 3'd0 && inValid) |=>
      (outValid && outI == (OUT_W'($past(inI)) <<< (OUT_W - IN_W))
                && outQ == (OUT_W'($past(inQ)) <<< (OUT_W - IN_W))));

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((satFlags & ($past(satFlags) & ~$past(clearSat))) ==
              ($past(satFlags) & ~$past(clearSat))));

  a_r9_clear_when_bypassed: assert property (@(posedge clk) disable iff (rst)
    (rateSel == 3'd0 && clearSat != 3'd0) |=> ((satFlags & $past(clearSat)) == 3'd0));

  a_r10_no_flag_in_x1: assert property (@(posedge clk) disable iff (rst)
    (rateSel == 3'd0 && clearSat == 3'd0) |=> $stable(satFlags));

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!outValid && satFlags == 3'd0 && outI == '0 && outQ == '0));
endmodule

bind hbc_interp hbc_interp_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) uChk (.*);

// File: tb/hbc_interp_test.sv
module hbc_interp_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] rateSel = 3'd0;
  logic inValid = 1'b0;
  logic signed [17:0] inI = '0, inQ = '0;
  logic [2:0] clearSat = 3'd0;
  logic outValid;
  logic signed [19:0] outI, outQ;
  logic [2:0] satFlags;

  int nChk = 0;
  int nFail = 0;
  int gotI[$], gotQ[$];
  bit [2:0] lastSat;

  always #10 clk = ~clk;

  hbc_interp uut (
    .clk(clk), .rst(rst), .rateSel(rateSel), .inValid(inValid), .inI(inI), .inQ(inQ),
    .clearSat(clearSat), .outValid(outValid), .outI(outI), .outQ(outQ), .satFlags(satFlags)
  );

  always @(negedge clk) begin
    if (!rst && outValid) begin
      gotI.push_back(int'(outI));
      gotQ.push_back(int'(outQ));
    end
  end

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int clip20(input int v, inout bit hit);
    if (v > 524287) begin hit = 1'b1; return 524287; end
    if (v < -524288) begin hit = 1'b1; return -524288; end
    return v;
  endfunction

  // R3 model: two outputs per input, filtered phase then copy phase.
  task automatic stageModel(input int g, ref int q[$], inout bit hit);
    int src[$];
    int p0 = 0, p1 = 0, p2 = 0;
    src = q;
    q.delete();
    foreach (src[k]) begin
      int a;
      a = -src[k] + 9 * p0 + 9 * p1 - p2;
      q.push_back(clip20(a * (1 << g) >>> 4, hit));
      q.push_back(p0 * (1 << g));
      p2 = p1; p1 = p0; p0 = src[k];
    end
  endtask

  task automatic runCase(input int mode, input int n, input int kind, input string tag);
    int xi[$], xq[$], ei[$], eq[$];
    int act, ip;
    bit [2:0] expSat;
    act = (mode >= 3) ? 3 : mode;
    ip = 1 << act;
    rst = 1'b1; inValid = 1'b0; rateSel = 3'(mode); clearSat = 3'd0;
    repeat (3) @(negedge clk);
    check(satFlags == 3'd0 && !outValid, "R11 flags/valid under reset", int'(satFlags), 0);
    rst = 1'b0;
    gotI.delete(); gotQ.delete();
    for (int i = 0; i < n; i++) begin
      int vi, vq;
      if (kind == 1) begin
        vi = (i % 4 < 2) ? 131071 : -131072;
        vq = ((i + 2) % 4 < 2) ? 131071 : -131072;
      end else begin
        vi = int'($urandom_range(0, 262143)) - 131072;
        vq = int'($urandom_range(0, 262143)) - 131072;
      end
      xi.push_back(vi); xq.push_back(vq);
      @(negedge clk);
      inValid = 1'b1; inI = 18'(vi); inQ = 18'(vq);
      for (int w = 1; w < ip + int'($urandom_range(0, 2)); w++) begin
        @(negedge clk);
        inValid = 1'b0;   // R12: garbage on the buses between strobes
        inI = 18'($urandom); inQ = 18'($urandom);
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (40) @(negedge clk);

    expSat = 3'd0;
    ei = xi; eq = xq;
    if (act == 0) begin
      foreach (ei[k]) begin ei[k] = xi[k] * 4; eq[k] = xq[k] * 4; end
    end
    for (int s = 0; s < act; s++) begin
      bit h = 1'b0;
      stageModel((s == 0) ? 2 : 0, ei, h);
      stageModel((s == 0) ? 2 : 0, eq, h);
      expSat[s] = h;
    end
    lastSat = expSat;

    check(gotI.size() == ei.size(), {"R1 output count ", tag}, gotI.size(), ei.size());
    for (int k = 0; k < ei.size() && k < gotI.size(); k++) begin
      check(gotI[k] == ei[k], {"R3/R12 I sample ", tag}, gotI[k], ei[k]);
      check(gotQ[k] == eq[k], {"R3/R12 Q sample ", tag}, gotQ[k], eq[k]);
    end
    check(satFlags == expSat, {"R8/R10 flags ", tag}, int'(satFlags), int'(expSat));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    check(!outValid && outI == 0 && outQ == 0 && satFlags == 0, "R11 reset state", int'(outI), 0);

    runCase(0, 30, 0, "R2 x1 random");
    runCase(0, 16, 1, "R10 x1 full scale");
    runCase(1, 30, 0, "R4 x2 random");
    runCase(1, 16, 1, "R7 x2 clipping");
    runCase(2, 24, 0, "R5 x4 random");
    runCase(3, 20, 0, "R6 x8 random");
    runCase(5, 12, 0, "R1 R6 code 5 acts as x8");
    runCase(7, 16, 1, "R7 x8 clipping");

    // R9: clear one bit, then the rest, with no samples flowing.
    @(negedge clk); clearSat = 3'b010;
    @(negedge clk); clearSat = 3'b000;
    check(satFlags == (lastSat & 3'b101), "R9 clear middle bit", int'(satFlags), int'(lastSat & 3'b101));
    @(negedge clk); clearSat = 3'b111;
    @(negedge clk); clearSat = 3'b000;
    check(satFlags == 3'd0, "R9 clear all", int'(satFlags), 0);
    repeat (3) @(negedge clk);
    check(satFlags == 3'd0, "R8 stays clear without clips", int'(satFlags), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule